// File: doc/BRIEF.md
# BCD Real-Time Clock Register Bank

This block keeps calendar time (seconds, minutes, hours, weekday, day of month, month and two-digit year) in packed BCD registers. A single-cycle `tick_i` pulse, expected once per second, advances the time. The carries ripple from seconds through to the year in the same clock edge, and the day of month rolls over at the length of the current month.

Software reaches the registers through a plain synchronous port: a 3-bit register index, write data, a write strobe and a registered read-data bus. Every field can be rewritten at any time. Each write is masked to the bits that field uses. A write whose masked value is not legal BCD, or is outside the field's range, leaves the field unchanged. A halt bit kept in the seconds register freezes the count. A flag bit kept in the weekday register is stored for software and plays no part in the count.

Register index map: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year, 7 unused.

Top module: `bcd_rtc_bank`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 0x00, weekday, day of month and month read 0x01, and the halt bit and the century flag are 0.
- R2: A tick adds one to seconds in BCD. Seconds 0x59 wraps to 0x00 and advances minutes. Minutes 0x59 wraps to 0x00 and advances hours. Hours 0x23 wraps to 0x00 and produces a day carry.
- R3: A day carry advances both the weekday and the day of month. Weekday 7 wraps to 1.
- R4: On a day carry, a day of month at or above the month length wraps to 0x01 and advances the month. The month length is 31, or 30 for months 4, 6, 9 and 11. February has 29 days when the binary year value is divisible by four and 28 otherwise.
- R5: On a month carry, month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00.
- R6: Bit 7 of a write to index 0 is the halt bit, and it is stored even when the seconds value in that write is rejected. While the halt bit is 1, ticks change no field. After it is cleared, counting resumes from the held value.
- R7: Writes are masked before the range check: seconds and minutes to bits 6:0, hours to bits 5:0, day of month to bits 5:0, month to bits 4:0, weekday to bits 2:0. The year uses all 8 bits.
- R8: A write is accepted only if both nibbles of the masked value are at most 9 and the value lies in its field's range: 0-59 for seconds and minutes, 0-23 for hours, 1-7 for weekday, 1-31 for day of month, 1-12 for month and 0-99 for year. A rejected write leaves the field unchanged.
- R9: Bit 6 of every write to index 3 is stored as the century flag, whether or not the weekday value is accepted. Index 3 reads as {0, flag, 000, weekday[2:0]}.
- R10: `rdata_o` is registered. One cycle after `addr_i` is presented it shows the register contents from before that clock edge. Index 0 returns {halt bit, seconds[6:0]}, indexes 1, 2, 4, 5 and 6 return the field, and index 7 returns 0x00 and ignores writes.
- R11: A tick that arrives in the same cycle as any write is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| addr_i | input | 3 | Register index |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Registered read data |

## Verification
The hardest states to reach are the deep rollovers: the end of February in leap and non-leap years, 30-day months, and the year wrap. Ticking there from reset would take millions of cycles. The bench writes each field to the second before the boundary and then sends a single tick.

Resuming after a halt with no time lost needs the halt bit cleared without touching the seconds. The bench does this by writing an out-of-range seconds value with bit 7 low. Random traffic then mixes ticks, writes that collide with ticks, and legal and illegal field values, all checked against a bench calendar model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 3;
  localparam int NUM_FIELDS = 7;

  typedef enum logic [ADDR_W-1:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_WDAY = 3'd3,
    F_DATE = 3'd4,
    F_MON  = 3'd5,
    F_YEAR = 3'd6,
    F_NONE = 3'd7
  } field_e;

  function automatic logic bcd_digits_ok(input logic [DATA_W-1:0] d);
    return (d[7:4] <= 4'd9) && (d[3:0] <= 4'd9);
  endfunction

  function automatic logic [DATA_W-1:0] bcd_to_bin(input logic [DATA_W-1:0] d);
    return ({4'd0, d[7:4]} * 8'd10) + {4'd0, d[3:0]};
  endfunction

  function automatic logic [DATA_W-1:0] bcd_inc(input logic [DATA_W-1:0] d);
    if (d[3:0] >= 4'd9) return {d[7:4] + 4'd1, 4'd0};
    else                return {d[7:4], d[3:0] + 4'd1};
  endfunction

  function automatic logic [DATA_W-1:0] field_floor(input int k);
    case (k)
      3, 4, 5: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] field_mask(input logic [ADDR_W-1:0] a);
    case (a)
      F_SEC, F_MIN:   return 8'h7F;
      F_HOUR, F_DATE: return 8'h3F;
      F_MON:          return 8'h1F;
      F_WDAY:         return 8'h07;
      F_YEAR:         return 8'hFF;
      default:        return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rtc_wr_check.sv
module rtc_wr_check
  import rtc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              accept_o,
  output logic [DATA_W-1:0] value_o
);
  logic [DATA_W-1:0] bin;
  logic              digits;

  always_comb begin
    value_o = wdata_i & field_mask(addr_i);
    bin     = bcd_to_bin(value_o);
    digits  = bcd_digits_ok(value_o);
    case (field_e'(addr_i))
      F_SEC, F_MIN: accept_o = digits && (bin <= 8'd59);
      F_HOUR:       accept_o = digits && (bin <= 8'd23);
      F_WDAY:       accept_o = digits && (bin >= 8'd1) && (bin <= 8'd7);
      F_DATE:       accept_o = digits && (bin >= 8'd1) && (bin <= 8'd31);
      F_MON:        accept_o = digits && (bin >= 8'd1) && (bin <= 8'd12);
      F_YEAR:       accept_o = digits;
      default:      accept_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_pkg::*;
(
  input  logic [DATA_W-1:0] month_i,
  input  logic [DATA_W-1:0] year_i,
  output logic [DATA_W-1:0] last_o
);
  logic [DATA_W-1:0] ybin;
  logic              leap;

  always_comb begin
    ybin = bcd_to_bin(year_i);
    leap = (ybin % 8'd4) == 8'd0;
    case (month_i)
      8'h02:                      last_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter logic [DATA_W-1:0] FLOOR = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] ld_val_i,
  input  logic [DATA_W-1:0] ceil_i,
  output logic [DATA_W-1:0] val_o,
  output logic              wrap_o
);
  logic [DATA_W-1:0] val_q;

  assign wrap_o = inc_i && (val_q >= ceil_i);
  assign val_o  = val_q;

  always_ff @(posedge clk) begin
    if (rst)        val_q <= FLOOR;
    else if (ld_i)  val_q <= ld_val_i;
    else if (inc_i) val_q <= wrap_o ? FLOOR : bcd_inc(val_q);
  end

  // R8: an accepted load lands exactly
  p_load_exact_r8: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> val_q == $past(ld_val_i));
  // R2: a field that is neither loaded nor stepped holds
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!ld_i && !inc_i) |=> $stable(val_q));
  // R4: a wrap returns the field to its floor
  p_wrap_floor_r4: assert property (@(posedge clk) disable iff (rst)
    (wrap_o && !ld_i) |=> val_q == FLOOR);
endmodule

// File: rtl/bcd_rtc_bank.sv
module bcd_rtc_bank
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0]     fval [NUM_FIELDS];
  logic [DATA_W-1:0]     ceil [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] inc, ld, wrap;
  logic [DATA_W-1:0]     wr_val, last_day;
  logic                  wr_ok, tick_ok, halt_q, cent_q;

  rtc_wr_check u_chk (
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .accept_o (wr_ok),
    .value_o  (wr_val)
  );

  rtc_month_len u_mlen (
    .month_i (fval[F_MON]),
    .year_i  (fval[F_YEAR]),
    .last_o  (last_day)
  );

  assign tick_ok = tick_i && !halt_q && !wr_i;

  always_comb begin
    ceil[F_SEC]  = 8'h59;
    ceil[F_MIN]  = 8'h59;
    ceil[F_HOUR] = 8'h23;
    ceil[F_WDAY] = 8'h07;
    ceil[F_DATE] = last_day;
    ceil[F_MON]  = 8'h12;
    ceil[F_YEAR] = 8'h99;
    inc[F_SEC]   = tick_ok;
    inc[F_MIN]   = wrap[F_SEC];
    inc[F_HOUR]  = wrap[F_MIN];
    inc[F_WDAY]  = wrap[F_HOUR];
    inc[F_DATE]  = wrap[F_HOUR];
    inc[F_MON]   = wrap[F_DATE];
    inc[F_YEAR]  = wrap[F_MON];
  end

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    assign ld[k] = wr_i && wr_ok && (addr_i == ADDR_W'(k));
    rtc_bcd_field #(.FLOOR(field_floor(k))) u_field (
      .clk      (clk),
      .rst      (rst),
      .inc_i    (inc[k]),
      .ld_i     (ld[k]),
      .ld_val_i (wr_val),
      .ceil_i   (ceil[k]),
      .val_o    (fval[k]),
      .wrap_o   (wrap[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q <= 1'b0;
      cent_q <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == F_SEC)  halt_q <= wdata_i[7];
      if (addr_i == F_WDAY) cent_q <= wdata_i[6];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else begin
      case (field_e'(addr_i))
        F_SEC:   rdata_o <= {halt_q, fval[F_SEC][6:0]};
        F_WDAY:  rdata_o <= {1'b0, cent_q, 3'b000, fval[F_WDAY][2:0]};
        F_NONE:  rdata_o <= '0;
        default: rdata_o <= fval[addr_i];
      endcase
    end
  end

  // R6: halted clock does not move seconds unless seconds are written
  p_halt_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    (halt_q && !(wr_i && addr_i == F_SEC)) |=> $stable(fval[F_SEC]));
  // R11: with a write to another register, seconds cannot step
  p_tick_drop_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i != F_SEC) |=> $stable(fval[F_SEC]));
  // R8: rejected hour write keeps hours (no carry possible during a write)
  p_reject_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == F_HOUR && !wr_ok) |=> $stable(fval[F_HOUR]));
  // R10: unused index reads zero
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (addr_i == F_NONE) |=> rdata_o == 8'h00);
  // R5: year carry out wraps the year to 00
  p_year_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    wrap[F_YEAR] |=> fval[F_YEAR] == 8'h00);
  // R2: seconds stay legal BCD within 0..59
  p_sec_range_r2: assert property (@(posedge clk) disable iff (rst)
    bcd_digits_ok(fval[F_SEC]) && fval[F_SEC] <= 8'h59);
  // R4: day of month never zero
  p_date_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    fval[F_DATE] != 8'h00);
endmodule

// File: tb/bcd_rtc_bank_bench.sv
module bcd_rtc_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0, rst = 1'b1, tick_i = 1'b0, wr_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;

  int vectors = 0, misses = 0, cycles = 0;
  int m_sec, m_min, m_hour, m_wday, m_date, m_mon, m_year;
  bit m_halt, m_cent;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_rtc_bank u_bcd_rtc_bank (
    .clk(clk), .rst(rst), .tick_i(tick_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .wr_i(wr_i), .rdata_o(rdata_o)
  );

  function automatic int to_bcd(int v); return ((v / 10) << 4) | (v % 10); endfunction
  function automatic bit digits_ok(int d); return (d[3:0] <= 9) && (d[7:4] <= 9); endfunction
  function automatic int from_bcd(int d); return d[7:4] * 10 + d[3:0]; endfunction

  function automatic int mdays(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int model_read(int a);
    case (a)
      0: return (int'(m_halt) << 7) | to_bcd(m_sec);
      1: return to_bcd(m_min);
      2: return to_bcd(m_hour);
      3: return (int'(m_cent) << 6) | m_wday;
      4: return to_bcd(m_date);
      5: return to_bcd(m_mon);
      6: return to_bcd(m_year);
      default: return 0;
    endcase
  endfunction

  task automatic model_write(int a, int d);
    int v, b;
    case (a)
      0: begin m_halt = d[7]; v = d & 'h7F; b = from_bcd(v);
           if (digits_ok(v) && b <= 59) m_sec = b; end
      1: begin v = d & 'h7F; b = from_bcd(v); if (digits_ok(v) && b <= 59) m_min = b; end
      2: begin v = d & 'h3F; b = from_bcd(v); if (digits_ok(v) && b <= 23) m_hour = b; end
      3: begin m_cent = d[6]; v = d & 'h07; if (v >= 1) m_wday = v; end
      4: begin v = d & 'h3F; b = from_bcd(v); if (digits_ok(v) && b >= 1 && b <= 31) m_date = b; end
      5: begin v = d & 'h1F; b = from_bcd(v); if (digits_ok(v) && b >= 1 && b <= 12) m_mon = b; end
      6: begin if (digits_ok(d)) m_year = from_bcd(d); end
      default: ;
    endcase
  endtask

  task automatic model_tick();
    if (++m_sec < 60) return;
    m_sec = 0;
    if (++m_min < 60) return;
    m_min = 0;
    if (++m_hour < 24) return;
    m_hour = 0;
    m_wday = (m_wday == 7) ? 1 : m_wday + 1;
    if (m_date >= mdays(m_mon, m_year)) begin
      m_date = 1;
      if (m_mon == 12) begin m_mon = 1; m_year = (m_year + 1) % 100; end
      else m_mon++;
    end else m_date++;
  endtask

  task automatic step(bit tk, bit w, int a, int d, string tag);
    int exp;
    tick_i = tk; wr_i = w; addr_i = a[2:0]; wdata_i = d[7:0];
    exp = model_read(a);
    @(negedge clk);
    vectors++;
    if (rdata_o !== exp[7:0]) begin
      misses++;
      $display("FAIL %s: index %0d read 0x%02h, expected 0x%02h", tag, a, rdata_o, exp[7:0]);
    end
    if (w) model_write(a, d);
    else if (tk && !m_halt) model_tick();
  endtask

  task automatic read_all(string tag);
    for (int a = 0; a < 8; a++) step(0, 0, a, 0, tag);
  endtask

  task automatic set_time(int y, int mo, int dt, int h, int mi, int s, int wd, string tag);
    step(0, 1, 6, y, tag); step(0, 1, 5, mo, tag); step(0, 1, 4, dt, tag);
    step(0, 1, 2, h, tag); step(0, 1, 1, mi, tag); step(0, 1, 0, s, tag);
    step(0, 1, 3, wd, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      misses++;
      $display("FAIL watchdog: %0d cycles, expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    m_sec = 0; m_min = 0; m_hour = 0; m_wday = 1; m_date = 1; m_mon = 1; m_year = 0;
    m_halt = 0; m_cent = 0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    read_all("R1 reset");

    // R2 R3 R5: full rollover at end of year 99
    set_time('h99, 'h12, 'h31, 'h23, 'h59, 'h59, 'h07, "R5 setup");
    step(1, 0, 0, 0, "R2 tick");
    read_all("R3 R5 year wrap");

    // R4: February, leap and non-leap, and a 30-day month
    set_time('h24, 'h02, 'h28, 'h23, 'h59, 'h59, 'h02, "R4 setup");
    step(1, 0, 4, 0, "R4"); read_all("R4 leap 29");
    set_time('h23, 'h02, 'h28, 'h23, 'h59, 'h59, 'h02, "R4 setup");
    step(1, 0, 4, 0, "R4"); read_all("R4 non-leap");
    set_time('h10, 'h04, 'h30, 'h23, 'h59, 'h59, 'h05, "R4 setup");
    step(1, 0, 4, 0, "R4"); read_all("R4 thirty");

    // R6: halt, then clear with a rejected seconds value
    step(0, 1, 0, 'hB0, "R6");
    repeat (5) step(1, 0, 0, 0, "R6 halted");
    step(0, 1, 0, 'h7F, "R6 resume");
    step(1, 0, 0, 0, "R6"); step(0, 0, 0, 0, "R6 counted");

    // R7 R8: masking and rejection
    step(0, 1, 0, 'h60, "R8"); step(0, 1, 0, 'h4A, "R8"); step(0, 0, 0, 0, "R8 sec");
    step(0, 1, 1, 'h5F, "R8"); step(0, 0, 1, 0, "R8 min");
    step(0, 1, 2, 'h24, "R8"); step(0, 0, 2, 0, "R8 hour");
    step(0, 1, 2, 'h92, "R7"); step(0, 0, 2, 0, "R7 hour mask");
    step(0, 1, 5, 'h13, "R8"); step(0, 1, 5, 'h00, "R8"); step(0, 0, 5, 0, "R8 month");
    step(0, 1, 5, 'hF2, "R7"); step(0, 0, 5, 0, "R7 month mask");
    step(0, 1, 4, 'h00, "R8"); step(0, 1, 4, 'h32, "R8"); step(0, 0, 4, 0, "R8 date");
    step(0, 1, 6, 'hA0, "R8"); step(0, 1, 6, 'h9A, "R8"); step(0, 0, 6, 0, "R8 year");
    // R9: century flag stored even with rejected weekday
    step(0, 1, 3, 'h48, "R9"); step(0, 0, 3, 0, "R9 flag");
    step(0, 1, 3, 'hCD, "R9"); step(0, 0, 3, 0, "R9 weekday");
    // R10: unused index ignores writes
    step(0, 1, 7, 'h55, "R10"); step(0, 0, 7, 0, "R10 unused");
    // R11: tick in a write cycle is dropped
    step(1, 1, 7, 'h00, "R11"); step(1, 1, 1, 'h10, "R11"); step(0, 0, 0, 0, "R11 sec");

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      int r, a, d;
      r = $urandom % 100;
      a = $urandom % 8;
      if (r < 12) begin
        if ($urandom % 2) d = $urandom % 256;
        else case (a)
          0: d = to_bcd($urandom % 60) | (($urandom % 8 == 0) ? 'h80 : 0);
          1: d = to_bcd($urandom % 60);
          2: d = to_bcd($urandom % 24);
          3: d = 1 + $urandom % 7;
          4: d = to_bcd(26 + $urandom % 6);
          5: d = to_bcd(1 + $urandom % 12);
          default: d = to_bcd($urandom % 100);
        endcase
        step($urandom % 2, 1, a, d, "R7 R8 R11 random write");
      end else begin
        step(($urandom % 4) != 0, 0, a, 0, "R2 R10 random tick");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule